// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the nibble-wide transmit stream of a 100 Mb/s media-independent interface into the serial line code for a twisted-pair or fiber link. Each accepted nibble becomes a five-bit code group. Start-of-stream and end-of-stream delimiters are placed around every frame, and idle fills the gaps between frames. The bits leave one per bit enable, most significant first. In copper mode they are whitened by an 11-bit stream cipher and mapped onto a three-level line. In fiber mode, or when scrambling is switched off, they go out unscrambled on a two-level NRZI output.

Everything runs on one clock, and the 125 MHz bit rate is given by the `bit_en` qualifier. The block raises `nib_rdy` on the bit slot where the next nibble is taken. The MAC-side source presents `txd`, `txen` and `txer` on that slot. While the link monitor reports the link as failed, only idle goes out, scrambled in copper mode.

Top module: `fe_tx_encoder`

## Requirements
- R1: Inside a frame, a nibble with `txen`=1 and `txer`=0 becomes the code group 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R2: When `txen` is first seen high while idle, the groups 11000 and then 10001 are sent in place of those two nibbles, whatever `txd` and `txer` carry.
- R3: The first nibble of a frame with `txen` low produces 01101. The next nibble slot always produces 00111, and `txen` is ignored on that slot. After that, idle 11111 is sent until `txen` is seen high, which starts a new 11000.
- R4: Inside a frame, a nibble with `txen`=1 and `txer`=1 produces 00100 in place of the data.
- R5: A group is taken from the inputs on a bit enable while `nib_rdy`=1. Its bits leave most significant first, one per following bit enable, so `nib_rdy` recurs every fifth enable. With `bit_en` low, no output changes.
- R6: In copper mode, every line bit is the code bit XOR a key bit. With an 11-bit state s reset to the seed, key = s[10] XOR s[8], and s becomes {s[9:0], key} on every bit enable. The state is never all zero.
- R7: In copper mode, `mlt_lvl` encodes +1 as 01, 0 as 00 and −1 as 11. A 1 bit moves the level to the next step of the cycle 0, +1, 0, −1. A 0 bit holds the level. `nrzi_out` stays 0.
- R8: When `mode_fx` or `scram_off` is 1, the key is not applied. A 1 bit toggles `nrzi_out`, a 0 bit holds it, and `mlt_lvl` stays 00.
- R9: A group taken while `link_fail`=1 is idle 11111 regardless of `txen`, and it ends any frame in progress. After release, `txen` high starts with 11000.
- R10: After reset, `mlt_lvl`=00, `nrzi_out`=0 and `nib_rdy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate qualifier, one line bit per high cycle |
| txd | input | 4 | Transmit nibble |
| txen | input | 1 | Frame enable for the nibble |
| txer | input | 1 | Error mark for the nibble |
| mode_fx | input | 1 | Fiber mode: no scrambling, NRZI output |
| scram_off | input | 1 | Scrambling disabled: NRZI output |
| link_fail | input | 1 | Link monitor reports failure; force idle |
| nib_rdy | output | 1 | Inputs are taken on the next bit enable |
| mlt_lvl | output | 2 | Three-level line symbol |
| nrzi_out | output | 1 | Two-level NRZI line bit |

## Verification
The clash of interest is framing against the forced idle. `link_fail` is raised on the very nibble slot where `txen` is high in mid-frame, once with `txer` also high. The link-fail choice must win in that slot, and the frame state must not survive the failure. The test decodes the line at the ports and descrambles it with an independent key stream. It expects idle groups for those slots and a fresh 11000/10001 pair after release. A second overlap comes from gaps in the bit enable that fall between a load and the bits that follow. The test judges it by checking that the line holds still during each gap and that the groups still decode in order.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;

   localparam int unsigned CG_W = 5;
   typedef logic [CG_W-1:0] cgroup_t;

   localparam cgroup_t CG_IDLE = 5'b11111;
   localparam cgroup_t CG_SSD1 = 5'b11000;
   localparam cgroup_t CG_SSD2 = 5'b10001;
   localparam cgroup_t CG_ESD1 = 5'b01101;
   localparam cgroup_t CG_ESD2 = 5'b00111;
   localparam cgroup_t CG_HALT = 5'b00100;

   localparam logic [1:0] LV_ZERO = 2'b00;
   localparam logic [1:0] LV_POS  = 2'b01;
   localparam logic [1:0] LV_NEG  = 2'b11;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_SSD2,
      FR_BODY,
      FR_ESD2
   } fr_state_e;

   function automatic cgroup_t nib_to_cg(input logic [3:0] nib);
      cgroup_t cg;
      unique case (nib)
         4'h0: cg = 5'b11110;
         4'h1: cg = 5'b01001;
         4'h2: cg = 5'b10100;
         4'h3: cg = 5'b10101;
         4'h4: cg = 5'b01010;
         4'h5: cg = 5'b01011;
         4'h6: cg = 5'b01110;
         4'h7: cg = 5'b01111;
         4'h8: cg = 5'b10010;
         4'h9: cg = 5'b10011;
         4'hA: cg = 5'b10110;
         4'hB: cg = 5'b10111;
         4'hC: cg = 5'b11010;
         4'hD: cg = 5'b11011;
         4'hE: cg = 5'b11100;
         default: cg = 5'b11101;
      endcase
      return cg;
   endfunction

endpackage

// File: rtl/fe_tx_framer.sv
module fe_tx_framer
   import fe_tx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       link_fail,
   input  logic       txen,
   input  logic       txer,
   input  logic [3:0] txd,
   output cgroup_t    cg_next
);

   fr_state_e st_q, st_d;

   always_comb begin
      st_d    = st_q;
      cg_next = CG_IDLE;
      if (link_fail) begin
         st_d    = FR_IDLE;
         cg_next = CG_IDLE;
      end else begin
         unique case (st_q)
            FR_IDLE: begin
               if (txen) begin
                  cg_next = CG_SSD1;
                  st_d    = FR_SSD2;
               end
            end
            FR_SSD2: begin
               cg_next = CG_SSD2;
               st_d    = FR_BODY;
            end
            FR_BODY: begin
               if (txen) begin
                  cg_next = txer ? CG_HALT : nib_to_cg(txd);
               end else begin
                  cg_next = CG_ESD1;
                  st_d    = FR_ESD2;
               end
            end
            default: begin
               cg_next = CG_ESD2;
               st_d    = FR_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_q <= FR_IDLE;
      else if (load) st_q <= st_d;
   end

endmodule

// File: rtl/fe_tx_serializer.sv
module fe_tx_serializer
   import fe_tx_pkg::*;
#(
   parameter int unsigned SYM_W = CG_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic [SYM_W-1:0] sym_in,
   output logic             nib_rdy,
   output logic             load,
   output logic             ser_bit
);

   localparam int unsigned SLOT_W = (SYM_W > 1) ? $clog2(SYM_W) : 1;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SYM_W - 1);

   logic [SLOT_W-1:0] slot_q;
   logic [SYM_W-1:0]  sh_q;

   assign nib_rdy = (slot_q == LAST_SLOT);
   assign load    = bit_en & nib_rdy;
   assign ser_bit = sh_q[SYM_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= LAST_SLOT;
         sh_q   <= '1;
      end else if (bit_en) begin
         if (nib_rdy) begin
            sh_q   <= sym_in;
            slot_q <= '0;
         end else begin
            sh_q   <= {sh_q[SYM_W-2:0], 1'b0};
            slot_q <= slot_q + SLOT_W'(1);
         end
      end
   end

endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler #(
   parameter int unsigned        W       = 11,
   parameter int unsigned        TAP     = 9,
   parameter logic [W-1:0]       SEED    = 11'h5A3,
   parameter bit                 PRESENT = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_en,
   output logic         key,
   output logic [W-1:0] state
);

   generate
      if (PRESENT) begin : g_lfsr
         logic [W-1:0] s_q;
         assign key   = s_q[W-1] ^ s_q[TAP-1];
         assign state = s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      s_q <= SEED;
            else if (bit_en) s_q <= {s_q[W-2:0], key};
         end
      end else begin : g_none
         assign key   = 1'b0;
         assign state = SEED;
      end
   endgenerate

endmodule

// File: rtl/fe_tx_line_coder.sv
module fe_tx_line_coder
   import fe_tx_pkg::*;
#(
   parameter bit HAS_NRZI = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       bypass,
   input  logic       line_bit,
   output logic [1:0] mlt_lvl,
   output logic       nrzi_out
);

   logic [1:0] lvl_q;
   logic       up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= LV_ZERO;
         up_q  <= 1'b1;
      end else if (bit_en) begin
         if (bypass) begin
            lvl_q <= LV_ZERO;
         end else if (line_bit) begin
            if (lvl_q == LV_ZERO) begin
               lvl_q <= up_q ? LV_POS : LV_NEG;
               up_q  <= ~up_q;
            end else begin
               lvl_q <= LV_ZERO;
            end
         end
      end
   end

   assign mlt_lvl = lvl_q;

   generate
      if (HAS_NRZI) begin : g_nrzi
         logic n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               n_q <= 1'b0;
            else if (bit_en) begin
               if (!bypass)           n_q <= 1'b0;
               else if (line_bit)     n_q <= ~n_q;
            end
         end
         assign nrzi_out = n_q;
      end else begin : g_no_nrzi
         assign nrzi_out = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder
   import fe_tx_pkg::*;
#(
   parameter int unsigned            LFSR_W       = 11,
   parameter int unsigned            LFSR_TAP     = 9,
   parameter logic [LFSR_W-1:0]      LFSR_SEED    = 11'h5A3,
   parameter bit                     SCRAMBLER_EN = 1'b1,
   parameter bit                     NRZI_EN      = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic [3:0] txd,
   input  logic       txen,
   input  logic       txer,
   input  logic       mode_fx,
   input  logic       scram_off,
   input  logic       link_fail,
   output logic       nib_rdy,
   output logic [1:0] mlt_lvl,
   output logic       nrzi_out
);

   initial begin
      assert (LFSR_SEED != '0) else $fatal(1, "scrambler seed must be nonzero");
      assert (LFSR_TAP > 0 && LFSR_TAP < LFSR_W) else $fatal(1, "scrambler tap out of range");
      assert (CG_W == 5) else $fatal(1, "code group width must be five");
   end

   cgroup_t           cg_next;
   logic              load;
   logic              ser_bit;
   logic              scr_key;
   logic [LFSR_W-1:0] scr_state;
   logic              bypass;
   logic              line_bit;

   assign bypass   = mode_fx | scram_off;
   assign line_bit = ser_bit ^ (scr_key & ~bypass);

   fe_tx_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .link_fail (link_fail),
      .txen      (txen),
      .txer      (txer),
      .txd       (txd),
      .cg_next   (cg_next)
   );

   fe_tx_serializer #(.SYM_W(CG_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .sym_in  (cg_next),
      .nib_rdy (nib_rdy),
      .load    (load),
      .ser_bit (ser_bit)
   );

   fe_tx_scrambler #(
      .W       (LFSR_W),
      .TAP     (LFSR_TAP),
      .SEED    (LFSR_SEED),
      .PRESENT (SCRAMBLER_EN)
   ) u_scr (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .key    (scr_key),
      .state  (scr_state)
   );

   fe_tx_line_coder #(.HAS_NRZI(NRZI_EN)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .bypass   (bypass),
      .line_bit (line_bit),
      .mlt_lvl  (mlt_lvl),
      .nrzi_out (nrzi_out)
   );

endmodule

// File: rtl/fe_tx_encoder_chk.sv
module fe_tx_encoder_chk
   import fe_tx_pkg::*;
#(
   parameter int unsigned LFSR_W = 11
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              bypass,
   input logic              nib_rdy,
   input logic [1:0]        mlt_lvl,
   input logic              nrzi_out,
   input logic [LFSR_W-1:0] lfsr_state
);

   assert_mlt_pos_no_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mlt_lvl == LV_POS) |=> (mlt_lvl != LV_NEG));

   assert_mlt_neg_no_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mlt_lvl == LV_NEG) |=> (mlt_lvl != LV_POS));

   assert_mlt_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mlt_lvl != 2'b10));

   assert_tx_nrzi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !bypass) |=> (nrzi_out == 1'b0));

   assert_bypass_mlt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && bypass) |=> (mlt_lvl == LV_ZERO));

   assert_hold_without_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(mlt_lvl) && $stable(nrzi_out) && $stable(nib_rdy)));

   assert_rdy_one_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && nib_rdy) |=> !nib_rdy);

   assert_lfsr_never_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lfsr_state != '0));

endmodule

bind fe_tx_encoder fe_tx_encoder_chk #(.LFSR_W(LFSR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_en     (bit_en),
   .bypass     (bypass),
   .nib_rdy    (nib_rdy),
   .mlt_lvl    (mlt_lvl),
   .nrzi_out   (nrzi_out),
   .lfsr_state (scr_state)
);

// File: tb/tb_fe_tx_encoder.sv
`timescale 1ns/1ps
module tb_fe_tx_encoder;

   localparam logic [10:0] SEED = 11'h5A3;
   localparam logic [1:0]  POS  = 2'b01;
   localparam logic [1:0]  NEG  = 2'b11;
   localparam int          NV   = 35;

   // {req[2:0], txen, txer, txd[3:0], expected code group[4:0]}
   localparam logic [13:0] VEC [NV] = '{
      {3'd3, 1'b0, 1'b0, 4'h0, 5'b11111},
      {3'd2, 1'b1, 1'b0, 4'h5, 5'b11000},
      {3'd2, 1'b1, 1'b0, 4'h5, 5'b10001},
      {3'd1, 1'b1, 1'b0, 4'h0, 5'b11110},
      {3'd1, 1'b1, 1'b0, 4'h1, 5'b01001},
      {3'd1, 1'b1, 1'b0, 4'h2, 5'b10100},
      {3'd1, 1'b1, 1'b0, 4'h3, 5'b10101},
      {3'd1, 1'b1, 1'b0, 4'h4, 5'b01010},
      {3'd1, 1'b1, 1'b0, 4'h5, 5'b01011},
      {3'd1, 1'b1, 1'b0, 4'h6, 5'b01110},
      {3'd1, 1'b1, 1'b0, 4'h7, 5'b01111},
      {3'd1, 1'b1, 1'b0, 4'h8, 5'b10010},
      {3'd1, 1'b1, 1'b0, 4'h9, 5'b10011},
      {3'd1, 1'b1, 1'b0, 4'hA, 5'b10110},
      {3'd1, 1'b1, 1'b0, 4'hB, 5'b10111},
      {3'd1, 1'b1, 1'b0, 4'hC, 5'b11010},
      {3'd1, 1'b1, 1'b0, 4'hD, 5'b11011},
      {3'd1, 1'b1, 1'b0, 4'hE, 5'b11100},
      {3'd1, 1'b1, 1'b0, 4'hF, 5'b11101},
      {3'd4, 1'b1, 1'b1, 4'hA, 5'b00100},
      {3'd1, 1'b1, 1'b0, 4'h3, 5'b10101},
      {3'd3, 1'b0, 1'b0, 4'h0, 5'b01101},
      {3'd3, 1'b0, 1'b0, 4'h0, 5'b00111},
      {3'd3, 1'b0, 1'b0, 4'h0, 5'b11111},
      {3'd2, 1'b1, 1'b1, 4'h2, 5'b11000},
      {3'd2, 1'b1, 1'b1, 4'h2, 5'b10001},
      {3'd4, 1'b1, 1'b1, 4'h9, 5'b00100},
      {3'd3, 1'b0, 1'b1, 4'h9, 5'b01101},
      {3'd3, 1'b1, 1'b0, 4'h7, 5'b00111},
      {3'd3, 1'b1, 1'b0, 4'h7, 5'b11000},
      {3'd2, 1'b1, 1'b0, 4'h5, 5'b10001},
      {3'd1, 1'b1, 1'b0, 4'hE, 5'b11100},
      {3'd3, 1'b0, 1'b0, 4'h0, 5'b01101},
      {3'd3, 1'b0, 1'b0, 4'h0, 5'b00111},
      {3'd3, 1'b0, 1'b0, 4'h0, 5'b11111}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_en;
   logic [3:0] txd;
   logic       txen;
   logic       txer;
   logic       mode_fx;
   logic       scram_off;
   logic       link_fail;
   logic       nib_rdy;
   logic [1:0] mlt_lvl;
   logic       nrzi_out;

   always #2.5 clk = ~clk;

   fe_tx_encoder #(.LFSR_SEED(SEED)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .txd       (txd),
      .txen      (txen),
      .txer      (txer),
      .mode_fx   (mode_fx),
      .scram_off (scram_off),
      .link_fail (link_fail),
      .nib_rdy   (nib_rdy),
      .mlt_lvl   (mlt_lvl),
      .nrzi_out  (nrzi_out)
   );

   int          checks = 0;
   int          fails  = 0;
   logic [10:0] b_lfsr;
   int          skip;
   int          bcnt;
   logic [4:0]  acc;
   logic [1:0]  p_mlt;
   logic [1:0]  last_nz;
   logic        p_nrzi;
   logic        gap;
   logic [4:0]  exp_q [$];
   string       tag_q [$];

   function automatic string tagname(input logic [2:0] id);
      case (id)
         3'd1:    return "R1";
         3'd2:    return "R2";
         3'd3:    return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cyc();
      logic       eb, byp, key, b;
      logic [1:0] want;
      logic [4:0] e;
      string      t;
      eb  = bit_en;
      byp = mode_fx | scram_off;
      @(posedge clk);
      @(negedge clk);
      if (eb) begin
         key    = b_lfsr[10] ^ b_lfsr[8];
         b_lfsr = {b_lfsr[9:0], key};
         if (byp) begin
            b = nrzi_out ^ p_nrzi;
            chk(mlt_lvl == 2'b00, "R8", "three-level output held at zero", mlt_lvl, 0);
         end else begin
            b = (mlt_lvl != p_mlt) ^ key;
            chk(nrzi_out == 1'b0, "R7", "NRZI output quiet in copper mode", nrzi_out, 0);
            if (mlt_lvl != p_mlt) begin
               if (p_mlt == 2'b00) begin
                  want = (last_nz == POS) ? NEG : POS;
                  chk(mlt_lvl == want, "R7", "level step out of zero", mlt_lvl, want);
               end else begin
                  chk(mlt_lvl == 2'b00, "R7", "level step back to zero", mlt_lvl, 0);
               end
            end
         end
         if (mlt_lvl != 2'b00) last_nz = mlt_lvl;
         if (skip > 0) begin
            skip--;
         end else begin
            acc = {acc[3:0], b};
            bcnt++;
            if (bcnt == 5) begin
               bcnt = 0;
               if (exp_q.size() > 0) begin
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  chk(acc == e, t, "code group", acc, e);
               end else begin
                  chk(1'b0, "R5", "group without a load", acc, 0);
               end
            end
         end
      end else begin
         chk(mlt_lvl == p_mlt && nrzi_out == p_nrzi, "R5", "line held without bit enable",
             {mlt_lvl, nrzi_out}, {p_mlt, p_nrzi});
      end
      p_mlt  = mlt_lvl;
      p_nrzi = nrzi_out;
   endtask

   task automatic send(input logic en, input logic er, input logic [3:0] d,
                       input logic [4:0] code, input string tag);
      while (!nib_rdy) begin
         bit_en = gap ? ~bit_en : 1'b1;
         cyc();
      end
      bit_en = 1'b1;
      txen   = en;
      txer   = er;
      txd    = d;
      exp_q.push_back(code);
      tag_q.push_back(tag);
      cyc();
   endtask

   task automatic walk_table();
      for (int i = 0; i < NV; i++) begin
         logic [13:0] v;
         v = VEC[i];
         send(v[10], v[9], v[8:5], v[4:0], tagname(v[13:11]));
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; bit_en = 1'b0; txd = 4'h0; txen = 1'b0; txer = 1'b0;
      mode_fx = 1'b0; scram_off = 1'b0; link_fail = 1'b0; gap = 1'b0;
      b_lfsr = SEED; skip = 1; bcnt = 0; acc = '0;
      p_mlt = 2'b00; p_nrzi = 1'b0; last_nz = NEG;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(mlt_lvl == 2'b00, "R10", "reset three-level output", mlt_lvl, 0);
      chk(nrzi_out == 1'b0, "R10", "reset NRZI output", nrzi_out, 0);
      chk(nib_rdy == 1'b1, "R10", "reset load slot", nib_rdy, 1);
      cyc();

      // copper mode, scrambled three-level (R1-style table, R6, R7)
      walk_table();
      // fiber mode, NRZI without key (R8)
      mode_fx = 1'b1;
      walk_table();
      // scrambling disabled in copper mode (R8)
      mode_fx = 1'b0; scram_off = 1'b1;
      walk_table();
      // back to scrambled output with gaps in the bit enable (R5, R6)
      scram_off = 1'b0; gap = 1'b1;
      walk_table();
      gap = 1'b0;

      // R9: link failure in mid-frame, clashing with TXEN and TXER
      send(1'b1, 1'b0, 4'h5, 5'b11000, "R2");
      send(1'b1, 1'b0, 4'h5, 5'b10001, "R2");
      send(1'b1, 1'b0, 4'h8, 5'b10010, "R1");
      link_fail = 1'b1;
      send(1'b1, 1'b0, 4'h8, 5'b11111, "R9");
      send(1'b1, 1'b1, 4'h4, 5'b11111, "R9");
      send(1'b0, 1'b0, 4'h0, 5'b11111, "R9");
      link_fail = 1'b0;
      send(1'b1, 1'b0, 4'h5, 5'b11000, "R9");
      send(1'b1, 1'b0, 4'h5, 5'b10001, "R9");
      send(1'b1, 1'b0, 4'h6, 5'b01110, "R1");
      send(1'b0, 1'b0, 4'h0, 5'b01101, "R9");
      send(1'b0, 1'b0, 4'h0, 5'b00111, "R3");
      send(1'b0, 1'b0, 4'h0, 5'b11111, "R3");
      send(1'b0, 1'b0, 4'h0, 5'b11111, "R3");
      send(1'b0, 1'b0, 4'h0, 5'b11111, "R3");

      finish_run();
   end

endmodule